// File: doc/BRIEF.md
# Stack Word Cache with Window Hit Detection

This block is a 64-word register file that holds the region of an operand stack nearest its top. The stack grows toward lower word addresses. A word is placed in the entry chosen by the six low bits of its word address, and no tag is kept. Whether an access hits is decided from where the address lies relative to two pointers supplied from outside: the top-of-stack pointer and the bottom pointer of the cached region.

Each request names an address kind: absolute, top-relative, locals-relative, frame-relative or debug. Top-relative offsets from -1 to 4 cover the four top stack words (offsets 1 to 4) and the two empty slots just above the top (offsets 0 and -1). These are taken as hits with no comparison. Locals, frame and debug accesses, and top-relative accesses outside that range, are checked against the window in the same cycle as the request. Absolute accesses and every window miss are passed to a data-cache port and leave the store untouched. Moving the pointers, spilling and filling belong to a separate controller.

Top module: `stack_word_cache`

## Requirements
- R1: The store has 64 entries, and an access that hits uses the entry given by bits [5:0] of its word address. No tag is compared, so two addresses with equal low bits share one entry.
- R2: A top-relative request (kind 1) with an offset from -1 to 4 inclusive is a hit whatever the pointer window holds.
- R3: The effective word address is the base plus the sign-extended offset. The base is the top pointer for kind 1, the locals pointer for kind 2 and the frame pointer for kind 3. For kind 0, kind 4 and kinds 5 to 7 the effective address is req_addr. A top-relative request with an offset outside -1..4 is judged by the window.
- R4: The window runs from top_ptr-3 up to and including bottom_ptr. It is computed with modulo-2^ADDR_W unsigned arithmetic, so it may wrap through address zero.
- R5: Kinds 2, 3 and 4 hit exactly when their address lies inside the window. Hit or miss is known in the request cycle: miss_valid is high combinationally during that cycle.
- R6: Kind 0 and kinds 5 to 7 always miss. On any miss, miss_valid is 1, and miss_addr, miss_write and miss_wdata carry the effective address, the direction and the write data.
- R7: A write that hits stores req_wdata in its entry at the clock edge. A write that misses changes no entry.
- R8: With READ_REG=1 (the default), rsp_valid and rsp_hit follow req_valid and the hit result one cycle later. rsp_rdata then holds the entry for a read hit and zero for a write or a miss. With READ_REG=0 the same values appear in the request cycle.
- R9: During and right after reset, rsp_valid, rsp_hit and rsp_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 3 | 0 absolute, 1 top, 2 locals, 3 frame, 4 debug, 5-7 absolute |
| req_offset | input | OFF_W | Signed word offset for kinds 1-3 |
| req_addr | input | ADDR_W | Word address for absolute and debug kinds |
| req_wdata | input | DATA_W | Write data |
| top_ptr | input | ADDR_W | Top-of-stack word pointer |
| locals_ptr | input | ADDR_W | Locals word pointer |
| frame_ptr | input | ADDR_W | Frame word pointer |
| bottom_ptr | input | ADDR_W | Deepest cached word address |
| rsp_valid | output | 1 | Response for a request |
| rsp_hit | output | 1 | Request was served by the store |
| rsp_rdata | output | DATA_W | Read data of a read hit, else 0 |
| miss_valid | output | 1 | Request forwarded to the data-cache port |
| miss_addr | output | ADDR_W | Effective word address of the miss |
| miss_write | output | 1 | Direction of the miss |
| miss_wdata | output | DATA_W | Write data of the miss |

## Verification
The assertions assume that bottom_ptr is at or above top_ptr in wrap-around terms, so the window is never empty. They also assume the pointers do not change in the cycle between a request and its registered response. The stimulus keeps the pointers fixed around each group of requests and changes them only while req_valid is low. It reads an entry only after that entry has been written, so no undefined store content reaches a compared output.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    KIND_ABS   = 3'd0,
    KIND_TOP   = 3'd1,
    KIND_LOCAL = 3'd2,
    KIND_FRAME = 3'd3,
    KIND_DEBUG = 3'd4
  } swc_kind_e;
endpackage

// File: rtl/swc_addr_gen.sv
module swc_addr_gen #(
  parameter int ADDR_W    = 30,
  parameter int OFF_W     = 8,
  parameter int TOP_BELOW = 1,
  parameter int TOP_ABOVE = 4
) (
  input  logic [2:0]        kind,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic [ADDR_W-1:0] top_ptr,
  input  logic [ADDR_W-1:0] locals_ptr,
  input  logic [ADDR_W-1:0] frame_ptr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              top_fast,
  output logic              stack_based
);
  import swc_pkg::*;

  localparam logic signed [OFF_W-1:0] OFF_MIN = OFF_W'(-TOP_BELOW);
  localparam logic signed [OFF_W-1:0] OFF_MAX = OFF_W'(TOP_ABOVE);

  function automatic logic [ADDR_W-1:0] add_offset(input logic [ADDR_W-1:0] base,
                                                   input logic [OFF_W-1:0] off);
    return base + {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic in_top_range(input logic [OFF_W-1:0] off);
    return ($signed(off) >= OFF_MIN) && ($signed(off) <= OFF_MAX);
  endfunction

  always_comb begin
    eff_addr    = abs_addr;
    stack_based = 1'b0;
    top_fast    = 1'b0;
    case (kind)
      KIND_TOP: begin
        eff_addr    = add_offset(top_ptr, offset);
        stack_based = 1'b1;
        top_fast    = in_top_range(offset);
      end
      KIND_LOCAL: begin
        eff_addr    = add_offset(locals_ptr, offset);
        stack_based = 1'b1;
      end
      KIND_FRAME: begin
        eff_addr    = add_offset(frame_ptr, offset);
        stack_based = 1'b1;
      end
      KIND_DEBUG: begin
        eff_addr    = abs_addr;
        stack_based = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/swc_window.sv
module swc_window #(
  parameter int ADDR_W = 30,
  parameter int GUARD  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] top_ptr,
  input  logic [ADDR_W-1:0] bottom_ptr,
  output logic              in_window
);
  localparam logic [ADDR_W-1:0] LOW_SPAN = ADDR_W'(GUARD - 1);

  function automatic logic window_test(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
    return (a - lo) <= (hi - lo);
  endfunction

  logic [ADDR_W-1:0] low_edge;
  assign low_edge  = top_ptr - LOW_SPAN;
  assign in_window = window_test(addr, low_edge, bottom_ptr);
endmodule

// File: rtl/swc_store.sv
module swc_store #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6,
  parameter bit READ_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_now;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rd_now = rd_en ? mem[idx] : '0;

  generate
    if (READ_REG) begin : g_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_now;
      end
      assign rdata = rd_q;
    end else begin : g_comb
      assign rdata = rd_now;
    end
  endgenerate
endmodule

// File: rtl/stack_word_cache.sv
module stack_word_cache #(
  parameter int ADDR_W    = 30,
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 8,
  parameter int IDX_W     = 6,
  parameter int GUARD     = 4,
  parameter int TOP_BELOW = 1,
  parameter int TOP_ABOVE = 4,
  parameter bit READ_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_kind,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] top_ptr,
  input  logic [ADDR_W-1:0] locals_ptr,
  input  logic [ADDR_W-1:0] frame_ptr,
  input  logic [ADDR_W-1:0] bottom_ptr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              miss_valid,
  output logic [ADDR_W-1:0] miss_addr,
  output logic              miss_write,
  output logic [DATA_W-1:0] miss_wdata
);
  logic [ADDR_W-1:0] eff_addr;
  logic              top_fast;
  logic              stack_based;
  logic              in_window;
  logic              hit_w;
  logic              store_wr;
  logic              store_rd;

  swc_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TOP_BELOW(TOP_BELOW), .TOP_ABOVE(TOP_ABOVE)
  ) u_agen (
    .kind(req_kind), .offset(req_offset), .abs_addr(req_addr),
    .top_ptr(top_ptr), .locals_ptr(locals_ptr), .frame_ptr(frame_ptr),
    .eff_addr(eff_addr), .top_fast(top_fast), .stack_based(stack_based)
  );

  swc_window #(.ADDR_W(ADDR_W), .GUARD(GUARD)) u_win (
    .addr(eff_addr), .top_ptr(top_ptr), .bottom_ptr(bottom_ptr), .in_window(in_window)
  );

  assign hit_w    = req_valid && (top_fast || (stack_based && in_window));
  assign store_wr = hit_w && req_write;
  assign store_rd = hit_w && !req_write;

  swc_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .READ_REG(READ_REG)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_wr), .rd_en(store_rd),
    .idx(eff_addr[IDX_W-1:0]), .wdata(req_wdata), .rdata(rsp_rdata)
  );

  assign miss_valid = req_valid && !hit_w;
  assign miss_addr  = eff_addr;
  assign miss_write = req_write;
  assign miss_wdata = req_wdata;

  generate
    if (READ_REG) begin : g_rsp_reg
      logic valid_q, hit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          hit_q   <= 1'b0;
        end else begin
          valid_q <= req_valid;
          hit_q   <= hit_w;
        end
      end
      assign rsp_valid = valid_q;
      assign rsp_hit   = hit_q;
    end else begin : g_rsp_comb
      assign rsp_valid = req_valid;
      assign rsp_hit   = hit_w;
    end
  endgenerate
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 8,
  parameter int TOP_BELOW = 1,
  parameter int TOP_ABOVE = 4,
  parameter bit READ_REG  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic [OFF_W-1:0]  req_offset,
  input logic              miss_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_rdata
);
  localparam logic signed [OFF_W-1:0] OFF_MIN = OFF_W'(-TOP_BELOW);
  localparam logic signed [OFF_W-1:0] OFF_MAX = OFF_W'(TOP_ABOVE);

  logic top_in_range;
  assign top_in_range = (req_kind == 3'd1) && ($signed(req_offset) >= OFF_MIN) &&
                        ($signed(req_offset) <= OFF_MAX);

  // R2
  a_r2_top_fast_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && top_in_range) |-> !miss_valid);

  // R6
  a_r6_abs_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd0 || req_kind > 3'd4)) |-> miss_valid);

  // R6
  a_r6_miss_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> req_valid);

  // R8
  a_r8_rdata_zero_off_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_rdata == '0));

  generate
    if (READ_REG) begin : g_reg_chk
      // R8
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
      // R8
      a_r8_hit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !miss_valid) |=> rsp_hit);
      // R8
      a_r8_miss_follows: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> !rsp_hit);
    end else begin : g_comb_chk
      // R5
      a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (req_valid && !miss_valid));
    end
  endgenerate
endmodule

bind stack_word_cache swc_checker #(
  .DATA_W(DATA_W), .OFF_W(OFF_W), .TOP_BELOW(TOP_BELOW),
  .TOP_ABOVE(TOP_ABOVE), .READ_REG(READ_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_offset(req_offset), .miss_valid(miss_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_stack_word_cache.sv
`timescale 1ns/1ps
module tb_stack_word_cache;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]    req_kind = '0;
  logic [OW-1:0] req_offset = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] top_ptr = '0, locals_ptr = '0, frame_ptr = '0, bottom_ptr = '0;
  logic          rsp_valid, rsp_hit, miss_valid, miss_write;
  logic [DW-1:0] rsp_rdata, miss_wdata;
  logic [AW-1:0] miss_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stack_word_cache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_offset(req_offset), .req_addr(req_addr),
    .req_wdata(req_wdata), .top_ptr(top_ptr), .locals_ptr(locals_ptr),
    .frame_ptr(frame_ptr), .bottom_ptr(bottom_ptr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .miss_valid(miss_valid),
    .miss_addr(miss_addr), .miss_write(miss_write), .miss_wdata(miss_wdata)
  );

  typedef struct packed {
    logic [2:0]        kind;
    logic signed [7:0] off;
    logic [29:0]       addr;
    logic              wr;
    logic [31:0]       wdata;
    logic              hit;
    logic [31:0]       rdata;
    logic [3:0]        rq;
  } vec_t;

  // pointers: top 100, bottom 120, locals 110, frame 118; window 97..120
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd2,  8'sd0,  30'd0,   1'b1, 32'hA1, 1'b1, 32'h0,  4'd7}, // R7 write locals 110
    '{3'd3,  8'sd2,  30'd0,   1'b1, 32'hB2, 1'b1, 32'h0,  4'd4}, // R4 bottom word 120
    '{3'd2,  8'sd0,  30'd0,   1'b0, 32'h0,  1'b1, 32'hA1, 4'd8}, // R8 read back
    '{3'd3,  8'sd2,  30'd0,   1'b0, 32'h0,  1'b1, 32'hB2, 4'd4},
    '{3'd3,  8'sd3,  30'd0,   1'b0, 32'h0,  1'b0, 32'h0,  4'd4}, // R4 above bottom
    '{3'd1,  8'sd4,  30'd0,   1'b1, 32'hC3, 1'b1, 32'h0,  4'd2}, // R2 top+4
    '{3'd2, -8'sd6,  30'd0,   1'b0, 32'h0,  1'b1, 32'hC3, 4'd3}, // R3 locals-6 = 104
    '{3'd1, -8'sd1,  30'd0,   1'b1, 32'hD4, 1'b1, 32'h0,  4'd2}, // R2 top-1 = 99
    '{3'd4,  8'sd0,  30'd99,  1'b0, 32'h0,  1'b1, 32'hD4, 4'd5}, // R5 debug
    '{3'd2, -8'sd13, 30'd0,   1'b1, 32'hE5, 1'b1, 32'h0,  4'd4}, // R4 low edge 97
    '{3'd1, -8'sd3,  30'd0,   1'b0, 32'h0,  1'b1, 32'hE5, 4'd3}, // R3 top-3 via window
    '{3'd2, -8'sd14, 30'd0,   1'b0, 32'h0,  1'b0, 32'h0,  4'd4}, // R4 96 below edge
    '{3'd1, -8'sd4,  30'd0,   1'b0, 32'h0,  1'b0, 32'h0,  4'd3}, // R3 top-4 misses
    '{3'd0,  8'sd0,  30'd110, 1'b1, 32'hFF, 1'b0, 32'h0,  4'd6}, // R6 absolute write
    '{3'd2,  8'sd0,  30'd0,   1'b0, 32'h0,  1'b1, 32'hA1, 4'd7}, // R7 unchanged
    '{3'd3,  8'sd3,  30'd0,   1'b1, 32'h77, 1'b0, 32'h0,  4'd7}, // R7 write miss
    '{3'd6,  8'sd0,  30'd99,  1'b0, 32'h0,  1'b0, 32'h0,  4'd6}  // R6 kind 6 absolute
  };

  function automatic logic [AW-1:0] expect_addr(input logic [2:0] k,
                                                input logic signed [7:0] o,
                                                input logic [AW-1:0] a);
    logic [AW-1:0] so;
    so = AW'(o);
    case (k)
      3'd1:    return top_ptr + so;
      3'd2:    return locals_ptr + so;
      3'd3:    return frame_ptr + so;
      default: return a;
    endcase
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] k, input logic signed [7:0] o,
                         input logic [AW-1:0] a, input logic w,
                         input logic [DW-1:0] wd, input logic eh,
                         input logic [DW-1:0] ed, input string rq);
    logic [AW-1:0] ea;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_kind = k; req_offset = o;
    req_addr = a; req_wdata = wd;
    ea = expect_addr(k, o, a);
    #1;
    check(rq, "miss_valid", 64'(miss_valid), 64'(!eh));
    if (!eh) begin
      check(rq, "miss_addr", 64'(miss_addr), 64'(ea));
      check(rq, "miss_write", 64'(miss_write), 64'(w));
      check(rq, "miss_wdata", 64'(miss_wdata), 64'(wd));
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rq, "rsp_hit", 64'(rsp_hit), 64'(eh));
    check(rq, "rsp_rdata", 64'(rsp_rdata), 64'((eh && !w) ? ed : 32'h0));
  endtask

  task automatic set_ptrs(input logic [AW-1:0] t, input logic [AW-1:0] b,
                          input logic [AW-1:0] l, input logic [AW-1:0] f);
    @(negedge clk);
    top_ptr = t; bottom_ptr = b; locals_ptr = l; frame_ptr = f;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 outputs in reset
    check("R9", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check("R9", "rsp_hit in reset", 64'(rsp_hit), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R9", "rsp_rdata after reset", 64'(rsp_rdata), 64'd0);

    set_ptrs(30'd100, 30'd120, 30'd110, 30'd118);
    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i].kind, VECS[i].off, VECS[i].addr, VECS[i].wr, VECS[i].wdata,
              VECS[i].hit, VECS[i].rdata, $sformatf("R%0d", VECS[i].rq));
    end

    // R1 174 shares entry 46 with 110, no tag
    set_ptrs(30'd150, 30'd180, 30'd174, 30'd0);
    run_req(3'd2, 8'sd0, 30'd0, 1'b0, 32'h0, 1'b1, 32'hA1, "R1");

    // R2 top+4 above an equal-pointer window still hits
    set_ptrs(30'd200, 30'd200, 30'd204, 30'd0);
    run_req(3'd1, 8'sd4, 30'd0, 1'b1, 32'h99, 1'b1, 32'h0, "R2");
    run_req(3'd2, 8'sd0, 30'd0, 1'b0, 32'h0, 1'b0, 32'h0, "R4");
    set_ptrs(30'd196, 30'd204, 30'd204, 30'd0);
    run_req(3'd2, 8'sd0, 30'd0, 1'b0, 32'h0, 1'b1, 32'h99, "R7");

    // R4 window wrapping through zero: low edge is all ones
    set_ptrs(30'd2, 30'd10, 30'd0, 30'd0);
    run_req(3'd2, -8'sd1, 30'd0, 1'b1, 32'h5A, 1'b1, 32'h0, "R4");
    run_req(3'd4, 8'sd0, 30'h3FFFFFFF, 1'b0, 32'h0, 1'b1, 32'h5A, "R4");
    run_req(3'd2, -8'sd2, 30'd0, 1'b0, 32'h0, 1'b0, 32'h0, "R4");

    // R8 idle cycle gives no response
    @(negedge clk);
    check("R8", "rsp_valid idle", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule